// File: doc/BRIEF.md
# MSI Interrupt Remapping Unit

This unit sits between peripheral devices and the interrupt controllers and vets every message-signalled interrupt before it is delivered. Each incoming message carries the requester ID of the device that sent it, the message data word and a destination. The unit uses the requester ID to read that device's entry from an internal device table. The delivery type, taken from the message data, then selects a per-device control that decides whether the message is dropped, forwarded as sent, or rewritten.

Fixed and arbitrated interrupts can be rewritten through a per-device remapping table, which is indexed by the low message data bits. The table entry supplies a new vector, delivery mode and destination. This lets the same input vector from two devices land in two different places. System-type interrupts (SMI, NMI, INIT, the two local interrupt lines and ExtInt) can only be passed or dropped. Every dropped message leaves the unit on the same output channel as a flagged record that carries the requester ID, the original data and destination, and a reason code.

Both tables are small synchronous RAMs that are loaded through simple write ports. The lookup is a fixed two-stage pipeline that takes at most one message per cycle. Output backpressure stalls the whole pipeline.

Top module: `irq_remap_unit`

## Requirements
- R1: While reset is high, and in the first cycle after it, out_valid is 0. in_ready is 1 once the pipeline is empty after reset.
- R2: A message accepted at one rising edge (in_valid and in_ready both high) is on the outputs right after the next rising edge, provided in_ready was high at that edge. It is taken at the edge after that. At most one message is accepted per edge.
- R3: While out_valid is high and out_ready is low, in_ready is low and every output holds its value. Stalled messages are neither lost nor reordered.
- R4: If bit 0 (valid) of the requester's device entry is 0, the message is blocked with reason 1, whatever its type.
- R5: The delivery type is message data bits 10:8. The types are 010 SMI, 011 LINT0, 100 NMI, 101 INIT, 110 LINT1 and 111 ExtInt. Each type is controlled by a device entry bit (bit 3 SMI, 4 NMI, 5 INIT, 6 LINT0, 7 LINT1, 8 ExtInt). When the bit is 1 the message passes unchanged. When it is 0 the message is blocked with reason 2.
- R6: Types 000 (fixed) and 001 (arbitrated) are controlled by device entry bits 2:1. The value 01 passes the message unchanged, 10 remaps it, and 00 or 11 blocks it with reason 2.
- R7: A remap reads the remap RAM at the address {device entry bits 9 and up (table select), message data bits 8:0}. Each entry holds a valid bit (bit 0), a mode (bits 3:1), a vector (bits 11:4) and a destination (bits 12 and up). The output data keeps the bits above 10 and takes the mode in bits 10:8 and the vector in bits 7:0. out_dest is set to the entry's destination.
- R8: A remap that hits an entry whose valid bit is 0 is blocked with reason 3.
- R9: A blocked message appears with out_blocked=1 and carries the requester ID, the original data, the original destination and a nonzero reason. A delivered message has out_blocked=0 and reason 0.
- R10: The same message data from two devices whose entries select different remap tables yields each table's own vector and destination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Incoming message present |
| in_ready | output | 1 | Unit accepts a message this cycle |
| in_rid | input | RID_W (4) | Requester ID |
| in_data | input | DATA_W (16) | Message data word |
| in_dest | input | DEST_W (8) | Message destination |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Downstream takes the result |
| out_blocked | output | 1 | Result is a block record |
| out_rid | output | RID_W (4) | Requester ID of the result |
| out_data | output | DATA_W (16) | Delivered or original data |
| out_dest | output | DEST_W (8) | Delivered or original destination |
| out_reason | output | 2 | 0 delivered, 1 bad device, 2 type blocked, 3 bad remap entry |
| dev_we | input | 1 | Device table write enable |
| dev_waddr | input | RID_W (4) | Device table write address |
| dev_wdata | input | 9+TBL_BITS (10) | Device table entry |
| map_we | input | 1 | Remap table write enable |
| map_waddr | input | TBL_BITS+9 (10) | Remap table write address |
| map_wdata | input | 12+DEST_W (20) | Remap table entry |

## Verification
Each table read feeds exactly one output record two edges later. A wrong table-select or index field therefore shows at once as a wrong vector or destination, or as a spurious reason 3, on that message's own result. A stage register that failed to hold during backpressure would show within one cycle: outputs would change while the message was stalled, or a message would be lost or duplicated in the ordered stream. A wrong type decode shows as the wrong pass or block outcome for the first message of the affected type from a device whose controls differ between types.

// File: rtl/irq_remap_pkg.sv
package irq_remap_pkg;

  // Delivery type carried in message data bits 10:8
  typedef enum logic [2:0] {
    CLS_FIXED  = 3'b000,
    CLS_ARB    = 3'b001,
    CLS_SMI    = 3'b010,
    CLS_LINT0  = 3'b011,
    CLS_NMI    = 3'b100,
    CLS_INIT   = 3'b101,
    CLS_LINT1  = 3'b110,
    CLS_EXTINT = 3'b111
  } irq_class_e;

  typedef enum logic [1:0] {
    RSN_NONE     = 2'd0,
    RSN_NO_DEV   = 2'd1,
    RSN_CLASS    = 2'd2,
    RSN_NO_ENTRY = 2'd3
  } block_reason_e;

  typedef enum logic [1:0] {
    FX_BLOCK  = 2'd0,
    FX_PASS   = 2'd1,
    FX_REMAP  = 2'd2,
    FX_BLOCK2 = 2'd3
  } fixed_mode_e;

  // Message data layout
  localparam int CLS_LSB = 8;
  localparam int IDX_W   = 9;
  localparam int VEC_W   = 8;
  localparam int MODE_W  = 3;

  // Device entry layout (table select sits above DEV_CTL_W)
  localparam int DEV_VALID_BIT = 0;
  localparam int DEV_FIX_LSB   = 1;
  localparam int DEV_PASS_LSB  = 3;
  localparam int PASS_N        = 6;
  localparam int DEV_CTL_W     = DEV_PASS_LSB + PASS_N;

  // Remap entry layout (destination sits above MAP_DEST_LSB)
  localparam int MAP_VALID_BIT = 0;
  localparam int MAP_MODE_LSB  = 1;
  localparam int MAP_VEC_LSB   = MAP_MODE_LSB + MODE_W;
  localparam int MAP_DEST_LSB  = MAP_VEC_LSB + VEC_W;

endpackage

// File: rtl/irq_sync_ram.sv
module irq_sync_ram #(
  parameter int WIDTH = 8,
  parameter int AW    = 4
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/irq_gate_decide.sv
module irq_gate_decide
  import irq_remap_pkg::*;
(
  input  logic                 dev_valid,
  input  logic [1:0]           fixed_ctl,
  input  logic [PASS_N-1:0]    pass_bits,   // smi, nmi, init, lint0, lint1, extint
  input  logic [MODE_W-1:0]    cls,
  input  logic                 entry_valid,
  output logic                 use_remap,
  output logic                 blocked,
  output block_reason_e        reason
);
  logic pass_ok;

  always_comb begin
    case (irq_class_e'(cls))
      CLS_SMI:    pass_ok = pass_bits[0];
      CLS_NMI:    pass_ok = pass_bits[1];
      CLS_INIT:   pass_ok = pass_bits[2];
      CLS_LINT0:  pass_ok = pass_bits[3];
      CLS_LINT1:  pass_ok = pass_bits[4];
      CLS_EXTINT: pass_ok = pass_bits[5];
      default:    pass_ok = 1'b0;
    endcase
  end

  always_comb begin
    use_remap = 1'b0;
    blocked   = 1'b0;
    reason    = RSN_NONE;
    if (!dev_valid) begin
      blocked = 1'b1;
      reason  = RSN_NO_DEV;
    end else if (cls == CLS_FIXED || cls == CLS_ARB) begin
      case (fixed_mode_e'(fixed_ctl))
        FX_PASS: ;
        FX_REMAP: begin
          if (entry_valid) begin
            use_remap = 1'b1;
          end else begin
            blocked = 1'b1;
            reason  = RSN_NO_ENTRY;
          end
        end
        default: begin
          blocked = 1'b1;
          reason  = RSN_CLASS;
        end
      endcase
    end else if (!pass_ok) begin
      blocked = 1'b1;
      reason  = RSN_CLASS;
    end
  end
endmodule

// File: rtl/irq_remap_unit.sv
module irq_remap_unit
  import irq_remap_pkg::*;
#(
  parameter int RID_W    = 4,
  parameter int DATA_W   = 16,
  parameter int DEST_W   = 8,
  parameter int TBL_BITS = 1,
  localparam int DEV_W   = DEV_CTL_W + TBL_BITS,
  localparam int MAP_AW  = TBL_BITS + IDX_W,
  localparam int MAP_W   = MAP_DEST_LSB + DEST_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [RID_W-1:0]  in_rid,
  input  logic [DATA_W-1:0] in_data,
  input  logic [DEST_W-1:0] in_dest,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_blocked,
  output logic [RID_W-1:0]  out_rid,
  output logic [DATA_W-1:0] out_data,
  output logic [DEST_W-1:0] out_dest,
  output logic [1:0]        out_reason,
  input  logic              dev_we,
  input  logic [RID_W-1:0]  dev_waddr,
  input  logic [DEV_W-1:0]  dev_wdata,
  input  logic              map_we,
  input  logic [MAP_AW-1:0] map_waddr,
  input  logic [MAP_W-1:0]  map_wdata
);

  // Whole pipeline advances together unless the result is held
  logic adv;
  logic s2_valid;
  assign adv      = !(s2_valid && !out_ready);
  assign in_ready = adv;

  // Stage 1: capture message, read device entry
  logic              s1_valid;
  logic [RID_W-1:0]  s1_rid;
  logic [DATA_W-1:0] s1_data;
  logic [DEST_W-1:0] s1_dest;
  logic [DEV_W-1:0]  dev_q;

  irq_sync_ram #(.WIDTH(DEV_W), .AW(RID_W)) u_dev_ram (
    .clk   (clk),
    .we    (dev_we),
    .waddr (dev_waddr),
    .wdata (dev_wdata),
    .re    (adv),
    .raddr (in_rid),
    .rdata (dev_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
    end else if (adv) begin
      s1_valid <= in_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      s1_rid  <= in_rid;
      s1_data <= in_data;
      s1_dest <= in_dest;
    end
  end

  // Stage 2: read remap entry from the table the device selects
  logic [MAP_AW-1:0]    map_raddr;
  logic [MAP_W-1:0]     map_q;
  logic [RID_W-1:0]     s2_rid;
  logic [DATA_W-1:0]    s2_data;
  logic [DEST_W-1:0]    s2_dest;
  logic [DEV_CTL_W-1:0] s2_ctl;

  assign map_raddr = {dev_q[DEV_W-1 -: TBL_BITS], s1_data[IDX_W-1:0]};

  irq_sync_ram #(.WIDTH(MAP_W), .AW(MAP_AW)) u_map_ram (
    .clk   (clk),
    .we    (map_we),
    .waddr (map_waddr),
    .wdata (map_wdata),
    .re    (adv),
    .raddr (map_raddr),
    .rdata (map_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s2_valid <= 1'b0;
    end else if (adv) begin
      s2_valid <= s1_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      s2_rid  <= s1_rid;
      s2_data <= s1_data;
      s2_dest <= s1_dest;
      s2_ctl  <= dev_q[DEV_CTL_W-1:0];
    end
  end

  // Decision on stage-2 state
  logic          use_remap;
  logic          blocked;
  block_reason_e reason;

  irq_gate_decide u_decide (
    .dev_valid   (s2_ctl[DEV_VALID_BIT]),
    .fixed_ctl   (s2_ctl[DEV_FIX_LSB +: 2]),
    .pass_bits   (s2_ctl[DEV_PASS_LSB +: PASS_N]),
    .cls         (s2_data[CLS_LSB +: MODE_W]),
    .entry_valid (map_q[MAP_VALID_BIT]),
    .use_remap   (use_remap),
    .blocked     (blocked),
    .reason      (reason)
  );

  logic [DATA_W-1:0] remapped;
  always_comb begin
    remapped = s2_data;
    remapped[CLS_LSB +: MODE_W] = map_q[MAP_MODE_LSB +: MODE_W];
    remapped[0 +: VEC_W]        = map_q[MAP_VEC_LSB +: VEC_W];
  end

  assign out_valid   = s2_valid;
  assign out_blocked = s2_valid && blocked;
  assign out_reason  = s2_valid ? reason : RSN_NONE;
  assign out_rid     = s2_rid;
  assign out_data    = use_remap ? remapped : s2_data;
  assign out_dest    = use_remap ? map_q[MAP_DEST_LSB +: DEST_W] : s2_dest;

endmodule

// File: rtl/irq_remap_checker.sv
module irq_remap_checker #(
  parameter int RID_W  = 4,
  parameter int DATA_W = 16,
  parameter int DEST_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic              out_blocked,
  input logic [RID_W-1:0]  out_rid,
  input logic [DATA_W-1:0] out_data,
  input logic [DEST_W-1:0] out_dest,
  input logic [1:0]        out_reason
);

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> !out_valid);

  assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) ##1 in_ready |=> out_valid);

  assert_stall_ready_R3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);

  assert_stall_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_rid)
                                   && $stable(out_dest) && $stable(out_blocked)
                                   && $stable(out_reason)));

  assert_reason_match_R9: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_blocked == (out_reason != 2'd0)));

  assert_block_needs_valid_R9: assert property (@(posedge clk) disable iff (rst)
    out_blocked |-> out_valid);

endmodule

bind irq_remap_unit irq_remap_checker #(
  .RID_W(RID_W), .DATA_W(DATA_W), .DEST_W(DEST_W)
) i_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_blocked(out_blocked),
  .out_rid(out_rid), .out_data(out_data), .out_dest(out_dest),
  .out_reason(out_reason)
);

// File: tb/test_irq_remap_unit.sv
module test_irq_remap_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [3:0]  in_rid = '0;
  logic [15:0] in_data = '0;
  logic [7:0]  in_dest = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic        out_blocked;
  logic [3:0]  out_rid;
  logic [15:0] out_data;
  logic [7:0]  out_dest;
  logic [1:0]  out_reason;
  logic        dev_we = 1'b0;
  logic [3:0]  dev_waddr = '0;
  logic [9:0]  dev_wdata = '0;
  logic        map_we = 1'b0;
  logic [9:0]  map_waddr = '0;
  logic [19:0] map_wdata = '0;

  always #4 clk = ~clk;   // 125 MHz

  irq_remap_unit i_irq_remap_unit (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_ready(in_ready), .in_rid(in_rid),
    .in_data(in_data), .in_dest(in_dest),
    .out_valid(out_valid), .out_ready(out_ready), .out_blocked(out_blocked),
    .out_rid(out_rid), .out_data(out_data), .out_dest(out_dest),
    .out_reason(out_reason),
    .dev_we(dev_we), .dev_waddr(dev_waddr), .dev_wdata(dev_wdata),
    .map_we(map_we), .map_waddr(map_waddr), .map_wdata(map_wdata)
  );

  int errors = 0;
  int checks = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Vector table: requester, data, dest -> blocked, data, dest, reason, requirement
  typedef struct packed {
    logic [3:0]  rid;
    logic [15:0] data;
    logic [7:0]  dest;
    logic        blk;
    logic [15:0] odata;
    logic [7:0]  odest;
    logic [1:0]  rsn;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{4'd0, 16'h0005, 8'h10, 1'b0, 16'h0141, 8'h22, 2'd0, 4'd7},
    '{4'd3, 16'h0005, 8'h10, 1'b0, 16'h0077, 8'h5A, 2'd0, 4'd10},
    '{4'd0, 16'hF906, 8'h33, 1'b0, 16'hF890, 8'h01, 2'd0, 4'd7},
    '{4'd0, 16'h0007, 8'h33, 1'b1, 16'h0007, 8'h33, 2'd3, 4'd8},
    '{4'd1, 16'h0005, 8'h44, 1'b0, 16'h0005, 8'h44, 2'd0, 4'd6},
    '{4'd4, 16'h0005, 8'h44, 1'b1, 16'h0005, 8'h44, 2'd2, 4'd6},
    '{4'd5, 16'h0105, 8'h44, 1'b1, 16'h0105, 8'h44, 2'd2, 4'd6},
    '{4'd2, 16'h0400, 8'h50, 1'b1, 16'h0400, 8'h50, 2'd1, 4'd4},
    '{4'd3, 16'h0402, 8'h51, 1'b0, 16'h0402, 8'h51, 2'd0, 4'd5},
    '{4'd3, 16'h0500, 8'h52, 1'b1, 16'h0500, 8'h52, 2'd2, 4'd5},
    '{4'd1, 16'h0700, 8'h53, 1'b1, 16'h0700, 8'h53, 2'd2, 4'd5},
    '{4'd0, 16'h0700, 8'h54, 1'b0, 16'h0700, 8'h54, 2'd0, 4'd5},
    '{4'd0, 16'h0200, 8'h55, 1'b0, 16'h0200, 8'h55, 2'd0, 4'd5},
    '{4'd1, 16'h0200, 8'h55, 1'b1, 16'h0200, 8'h55, 2'd2, 4'd5},
    '{4'd0, 16'h0300, 8'h56, 1'b0, 16'h0300, 8'h56, 2'd0, 4'd5},
    '{4'd1, 16'h0600, 8'h57, 1'b1, 16'h0600, 8'h57, 2'd2, 4'd5},
    '{4'd2, 16'h0005, 8'h58, 1'b1, 16'h0005, 8'h58, 2'd1, 4'd4}
  };

  function automatic string tag_name(input logic [3:0] n);
    case (n)
      4'd2:    return "R2";
      4'd3:    return "R3";
      4'd4:    return "R4";
      4'd5:    return "R5";
      4'd6:    return "R6";
      4'd7:    return "R7";
      4'd8:    return "R8";
      4'd10:   return "R10";
      default: return "R9";
    endcase
  endfunction

  // Expected result stream, consumed in order by the monitor
  logic [30:0] e_pack [64];
  string       e_tag  [64];
  int          exp_n = 0;
  int          got_n = 0;

  always @(negedge clk) begin
    if (!rst && out_valid && out_ready) begin
      if (got_n < exp_n) begin
        chk({out_rid, out_blocked, out_data, out_dest, out_reason} == e_pack[got_n],
            e_tag[got_n], "result {rid,blk,data,dest,reason}",
            {1'b0, out_rid, out_blocked, out_data, out_dest, out_reason},
            {1'b0, e_pack[got_n]});
      end else begin
        chk(1'b0, "R3", "unexpected extra result", {16'h0, out_data}, 32'h0);
      end
      got_n++;
    end
  end

  task automatic send(input logic [3:0] rid, input logic [15:0] data, input logic [7:0] dest,
                      input logic blk, input logic [15:0] od, input logic [7:0] odst,
                      input logic [1:0] rsn, input string tag);
    e_pack[exp_n] = {rid, blk, od, odst, rsn};
    e_tag[exp_n]  = blk ? {tag, " R9"} : tag;
    exp_n++;
    @(negedge clk);
    in_valid = 1'b1;
    in_rid   = rid;
    in_data  = data;
    in_dest  = dest;
    while (!in_ready) @(negedge clk);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 100 && got_n < exp_n; i++) @(negedge clk);
  endtask

  task automatic wr_dev(input logic [3:0] a, input logic [9:0] d);
    @(negedge clk);
    dev_we = 1'b1; dev_waddr = a; dev_wdata = d;
    @(negedge clk);
    dev_we = 1'b0;
  endtask

  task automatic wr_map(input logic [9:0] a, input logic [19:0] d);
    @(negedge clk);
    map_we = 1'b1; map_waddr = a; map_wdata = d;
    @(negedge clk);
    map_we = 1'b0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "R2", "watchdog expired", 32'h0, 32'h1);
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: idle state right after reset
    chk(out_valid == 1'b0, "R1", "out_valid during reset", {31'h0, out_valid}, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1", "out_valid after reset", {31'h0, out_valid}, 32'h0);
    chk(in_ready == 1'b1, "R1", "in_ready after reset", {31'h0, in_ready}, 32'h1);

    // Device entries: bit0 valid, 2:1 fixed ctl, 3..8 pass bits, 9 table select
    wr_dev(4'd0, 10'h1FD);  // remap, all pass, table 0
    wr_dev(4'd1, 10'h203);  // fixed pass, all others block, table 1
    wr_dev(4'd2, 10'h1FC);  // not valid
    wr_dev(4'd3, 10'h215);  // remap, NMI pass only, table 1
    wr_dev(4'd4, 10'h007);  // fixed ctl 11
    wr_dev(4'd5, 10'h001);  // fixed ctl 00
    // Remap entries: bit0 valid, 3:1 mode, 11:4 vector, 19:12 dest
    wr_map(10'h005, 20'h22413);
    wr_map(10'h205, 20'h5A771);
    wr_map(10'h106, 20'h01901);
    wr_map(10'h007, 20'h33FFE);

    // Table of vectors sent back to back
    for (int i = 0; i < NV; i++) begin
      send(VECS[i].rid, VECS[i].data, VECS[i].dest, VECS[i].blk,
           VECS[i].odata, VECS[i].odest, VECS[i].rsn, tag_name(VECS[i].req));
    end
    idle();
    drain();

    // R2: latency of a lone message
    send(4'd1, 16'h0005, 8'h60, 1'b0, 16'h0005, 8'h60, 2'd0, "R2");
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid == 1'b0, "R2", "out_valid one edge after accept", {31'h0, out_valid}, 32'h0);
    @(negedge clk);
    chk(out_valid == 1'b1, "R2", "out_valid two edges after accept", {31'h0, out_valid}, 32'h1);
    drain();

    // R3: backpressure holds output and stops intake, no loss
    @(posedge clk);
    #1 out_ready = 1'b0;
    fork
      begin
        send(4'd1, 16'h0005, 8'h61, 1'b0, 16'h0005, 8'h61, 2'd0, "R3");
        send(4'd1, 16'h0005, 8'h62, 1'b0, 16'h0005, 8'h62, 2'd0, "R3");
        send(4'd1, 16'h0005, 8'h63, 1'b0, 16'h0005, 8'h63, 2'd0, "R3");
        idle();
      end
      begin
        repeat (8) @(negedge clk);
        chk(in_ready == 1'b0, "R3", "in_ready while stalled", {31'h0, in_ready}, 32'h0);
        chk(out_valid && out_dest == 8'h61, "R3", "held first result dest",
            {24'h0, out_dest}, 32'h61);
        @(posedge clk);
        #1 out_ready = 1'b1;
      end
    join
    drain();
    chk(got_n == exp_n, "R3", "results received", got_n, exp_n);

    finish_run();
  end

endmodule